// File: doc/BRIEF.md
# Held-Request Memory Port Sequencer

This block sits between a simple word-request client and an external memory controller. The controller accepts commands through an enable/ready handshake and write data through a second enable/ready handshake. Ready may fall at any moment, for example during refresh. The sequencer turns each client request into a single-word command. It raises each enable and keeps it high until the controller takes it. It tests ready in the same cycle that enable is driven, so a ready that falls on the first enable cycle never loses the request.

A read finishes when the controller strobes its read-data-valid line. The word is then handed back to the client with a one-cycle valid pulse. A write finishes once both the command and its data have been taken, in either order. A sticky stall flag records that the client closed its transfer window while a read was still outstanding. A copy of that flag is carried through a flop chain into a second clock domain, where an observer can see it.

Top module: `memseq_top`

## Requirements
- R1: Once `cmd_en` or `wd_en` is high, it stays high on every following cycle until a clock edge where the matching ready is also high.
- R2: A handshake is taken only at an edge where its enable and ready are both high. The enable is low in the cycle after that edge, and each request yields exactly one command acceptance.
- R3: If `cmd_rdy` is low in the very first cycle of `cmd_en`, the request is still carried out correctly.
- R4: A stretch of 32 or more cycles of low ready is waited out with enable held, and the operation then completes.
- R5: A write raises `cmd_en` (with `cmd_write`=1) and `wd_en` together. It completes once both handshakes have been taken, in any order or on the same edge, and then the addressed word holds the written data. `wd_en` is never high for a read.
- R6: After a read command is taken, the sequencer waits for `rsp_valid`. In the cycle after that strobe, `rd_data` holds the strobed word, `rd_valid` is high for exactly one cycle, and `busy` is low.
- R7: When `req_valid` is high at an edge while `busy` is low, the request is taken and `busy` is high in the next cycle. While `busy` is high, `req_valid` is ignored and the command address does not change.
- R8: `err_flag` is set at an edge where `window_end` is high while a read is outstanding. A read is outstanding while its command is not yet taken, or while it waits for data with no `rsp_valid` in that cycle. `window_end` with no outstanding read leaves the flag low.
- R9: `err_flag` stays set until an edge with `err_clear` high. Clear takes priority over set.
- R10: `err_shadow` follows `err_flag` through two `obs_clk` flops. It is still low half a `clk` period after the flag rises, and it matches the flag within four `obs_clk` cycles.
- R11: After reset, `busy`, `cmd_en`, `wd_en`, `rd_valid`, `err_flag` and `err_shadow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer and controller clock |
| rst | input | 1 | Synchronous active-high reset, clk domain |
| req_valid | input | 1 | Client request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Client word address |
| req_wdata | input | DW | Client write word |
| busy | output | 1 | A request is in progress |
| rd_valid | output | 1 | One-cycle pulse, read word available |
| rd_data | output | DW | Returned read word |
| window_end | input | 1 | Client transfer window closes |
| err_clear | input | 1 | Synchronous clear of the stall flag |
| err_flag | output | 1 | Sticky stall flag |
| obs_clk | input | 1 | Observer domain clock |
| obs_rst | input | 1 | Synchronous active-high reset, obs_clk domain |
| err_shadow | output | 1 | Stall flag copied into the observer domain |
| cmd_en | output | 1 | Command enable to the controller |
| cmd_write | output | 1 | Command kind, 1 = write |
| cmd_addr | output | AW | Command address |
| cmd_rdy | input | 1 | Controller ready for a command |
| wd_en | output | 1 | Write-data enable to the controller |
| wd_data | output | DW | Write word |
| wd_rdy | input | 1 | Controller ready for write data |
| rsp_valid | input | 1 | Controller read-data strobe |
| rsp_data | input | DW | Controller read word |

## Verification
The assertions assume that the controller strobes `rsp_valid` only for a read it has taken and still owes. They also assume that `window_end` and `err_clear` are synchronous to `clk`. The bench's controller model answers only accepted reads, after a set latency. It drives both ready lines at the falling edge, from counters that can drop ready exactly on the first cycle of an enable or hold it low for 32 cycles. The client stimulus is driven at the falling edge as well.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

    localparam int unsigned ADDR_W_DEF = 12;
    localparam int unsigned DATA_W_DEF = 16;
    localparam int unsigned SYNC_DEF   = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_WRITE
    } seq_state_e;

    // A handshake leg is finished if it is no longer enabled or is taken now.
    function automatic logic leg_clear(input logic en, input logic taken);
        return !en || taken;
    endfunction

    // A read still owes data to the client in this cycle.
    function automatic logic read_outstanding(input seq_state_e st, input logic strobe);
        return (st == ST_RD_CMD) || ((st == ST_RD_WAIT) && !strobe);
    endfunction

endpackage

// File: rtl/memseq_hold.sv
module memseq_hold (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rdy,
    output logic en,
    output logic taken
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (start) begin
            en_q <= 1'b1;
        end else if (en_q && rdy) begin
            en_q <= 1'b0;
        end
    end

    assign en    = en_q;
    assign taken = en_q && rdy;

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (en && !rdy) |=> en);

    assert_release_R2: assert property (@(posedge clk) disable iff (rst)
        (en && rdy) |=> !en);

endmodule

// File: rtl/memseq_stall_flag.sv
module memseq_stall_flag #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag,
    input  logic obs_clk,
    input  logic obs_rst,
    output logic shadow
);

    localparam int unsigned LAST = STAGES - 1;

    logic              flag_q;
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end
    end

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge obs_clk) begin
                if (obs_rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], flag_q};
                end
            end
        end else begin : g_single
            always_ff @(posedge obs_clk) begin
                if (obs_rst) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= flag_q;
                end
            end
        end
    endgenerate

    assign flag   = flag_q;
    assign shadow = chain_q[LAST];

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_i) |=> flag);

    assert_noset_R8: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set_i) |=> !flag);

endmodule

// File: rtl/memseq_top.sv
module memseq_top
    import memseq_pkg::*;
#(
    parameter int unsigned AW          = ADDR_W_DEF,
    parameter int unsigned DW          = DATA_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          window_end,
    input  logic          err_clear,
    output logic          err_flag,
    input  logic          obs_clk,
    input  logic          obs_rst,
    output logic          err_shadow,
    output logic          cmd_en,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    input  logic          cmd_rdy,
    output logic          wd_en,
    output logic [DW-1:0] wd_data,
    input  logic          wd_rdy,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data
);

    typedef struct packed {
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    seq_state_e    state_q, state_d;
    req_t          req_q;
    logic          take;
    logic          cmd_taken, wd_taken;
    logic          rd_valid_q;
    logic [DW-1:0] rd_data_q;
    logic          stall_set;

    assign take = (state_q == ST_IDLE) && req_valid;

    memseq_hold u_cmd_leg (
        .clk   (clk),
        .rst   (rst),
        .start (take),
        .rdy   (cmd_rdy),
        .en    (cmd_en),
        .taken (cmd_taken)
    );

    memseq_hold u_wd_leg (
        .clk   (clk),
        .rst   (rst),
        .start (take && req_write),
        .rdy   (wd_rdy),
        .en    (wd_en),
        .taken (wd_taken)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = req_write ? ST_WRITE : ST_RD_CMD;
            ST_RD_CMD:  if (cmd_taken) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (rsp_valid) state_d = ST_IDLE;
            ST_WRITE:   if (leg_clear(cmd_en, cmd_taken) && leg_clear(wd_en, wd_taken))
                            state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            state_q    <= state_d;
            rd_valid_q <= (state_q == ST_RD_WAIT) && rsp_valid;
            if (take) begin
                req_q <= '{write: req_write, addr: req_addr, wdata: req_wdata};
            end
            if ((state_q == ST_RD_WAIT) && rsp_valid) begin
                rd_data_q <= rsp_data;
            end
        end
    end

    assign stall_set = window_end && read_outstanding(state_q, rsp_valid);

    memseq_stall_flag #(.STAGES(SYNC_STAGES)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .set_i   (stall_set),
        .clr_i   (err_clear),
        .flag    (err_flag),
        .obs_clk (obs_clk),
        .obs_rst (obs_rst),
        .shadow  (err_shadow)
    );

    assign busy      = (state_q != ST_IDLE);
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign cmd_write = req_q.write;
    assign cmd_addr  = req_q.addr;
    assign wd_data   = req_q.wdata;

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_addr));

    assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    assert_wd_only_write_R5: assert property (@(posedge clk) disable iff (rst)
        wd_en |-> cmd_write);

    assert_rdvalid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: tb/memseq_top_test.sv
module memseq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int OBS_PERIOD = 14;

    logic        clk = 1'b0, obs_clk = 1'b0;
    logic        rst, obs_rst;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [15:0] req_wdata;
    logic        busy, rd_valid;
    logic [15:0] rd_data;
    logic        window_end, err_clear, err_flag, err_shadow;
    logic        cmd_en, cmd_write;
    logic [11:0] cmd_addr;
    logic        cmd_rdy, wd_en, wd_rdy, rsp_valid;
    logic [15:0] wd_data, rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(OBS_PERIOD/2) obs_clk = ~obs_clk;

    memseq_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .window_end(window_end),
        .err_clear(err_clear), .err_flag(err_flag), .obs_clk(obs_clk),
        .obs_rst(obs_rst), .err_shadow(err_shadow), .cmd_en(cmd_en),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_rdy(cmd_rdy),
        .wd_en(wd_en), .wd_data(wd_data), .wd_rdy(wd_rdy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int  errs = 0, checks = 0;
    bit  finished = 0;

    // Controller model state
    int          cmd_low_n = 0, wd_low_n = 0, rd_lat = 1;
    int          cmd_hold = 0, wd_hold = 0, rsp_cnt = 0;
    int          cmd_acc = 0, wd_acc = 0, hold_viol = 0;
    bit          prev_cmd_en = 0, prev_wd_en = 0, cmd_wait = 0, wd_wait = 0;
    bit          wa_ok = 0, wdat_ok = 0;
    logic [3:0]  rsp_addr, wa;
    logic [15:0] wdat;
    logic [15:0] mem [16];

    always @(negedge clk) begin
        if (rst) begin
            rsp_valid = 0; rsp_cnt = 0; cmd_rdy = 1; wd_rdy = 1;
            prev_cmd_en = 0; prev_wd_en = 0; cmd_wait = 0; wd_wait = 0;
        end else begin
            rsp_valid = 0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rsp_valid = 1;
                    rsp_data  = mem[rsp_addr];
                end
            end
            if (cmd_wait && !cmd_en) hold_viol++;
            if (wd_wait && !wd_en) hold_viol++;
            if (cmd_en && !prev_cmd_en) cmd_hold = cmd_low_n;
            if (wd_en && !prev_wd_en) wd_hold = wd_low_n;
            cmd_rdy = (cmd_hold == 0);
            if (cmd_hold > 0) cmd_hold--;
            wd_rdy = (wd_hold == 0);
            if (wd_hold > 0) wd_hold--;
            cmd_wait = cmd_en && !cmd_rdy;
            wd_wait  = wd_en && !wd_rdy;
            if (cmd_en && cmd_rdy) begin
                cmd_acc++;
                if (!cmd_write) begin
                    rsp_cnt  = rd_lat;
                    rsp_addr = cmd_addr[3:0];
                end else begin
                    wa = cmd_addr[3:0]; wa_ok = 1;
                end
            end
            if (wd_en && wd_rdy) begin
                wd_acc++;
                wdat = wd_data; wdat_ok = 1;
            end
            if (wa_ok && wdat_ok) begin
                mem[wa] = wdat; wa_ok = 0; wdat_ok = 0;
            end
            prev_cmd_en = cmd_en;
            prev_wd_en  = wd_en;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic do_req(input bit w, input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_acc = 0; wd_acc = 0; hold_viol = 0;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1, "R7", "busy after take", busy, 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    endtask

    task automatic t_write(input logic [11:0] a, input logic [15:0] d,
                           input int cl, input int wl, input string req);
        cmd_low_n = cl; wd_low_n = wl;
        do_req(1, a, d);
        wait_idle();
        @(negedge clk);
        check(cmd_acc == 1, req, "write cmd accepts", cmd_acc, 1);
        check(wd_acc == 1, "R5", "write data accepts", wd_acc, 1);
        check(mem[a[3:0]] == d, "R5", "stored word", mem[a[3:0]], d);
        check(hold_viol == 0, "R1", "enable dropped while not ready", hold_viol, 0);
        cmd_low_n = 0; wd_low_n = 0;
    endtask

    task automatic t_read(input logic [11:0] a, input logic [15:0] exp,
                          input int cl, input int lat, input string req);
        int n;
        cmd_low_n = cl; rd_lat = lat;
        do_req(0, a, 16'h0);
        n = 0;
        while (!rd_valid && n < 300) begin @(negedge clk); n++; end
        check(rd_valid == 1, req, "rd_valid seen", rd_valid, 1);
        check(rd_data == exp, req, "read word", rd_data, exp);
        check(busy == 0, "R6", "busy low with rd_valid", busy, 0);
        @(negedge clk);
        check(rd_valid == 0, "R6", "rd_valid one cycle", rd_valid, 0);
        check(cmd_acc == 1, "R2", "read cmd accepts", cmd_acc, 1);
        check(hold_viol == 0, "R1", "enable dropped while not ready", hold_viol, 0);
        cmd_low_n = 0; rd_lat = 1;
    endtask

    task automatic t_reset();
        check(busy == 0, "R11", "busy", busy, 0);
        check(cmd_en == 0, "R11", "cmd_en", cmd_en, 0);
        check(wd_en == 0, "R11", "wd_en", wd_en, 0);
        check(rd_valid == 0, "R11", "rd_valid", rd_valid, 0);
        check(err_flag == 0, "R11", "err_flag", err_flag, 0);
        check(err_shadow == 0, "R11", "err_shadow", err_shadow, 0);
    endtask

    task automatic t_ignore_busy();
        logic [15:0] old;
        old = mem[5];
        rd_lat = 20;
        do_req(0, 12'h003, 16'h0);
        req_valid = 1; req_write = 1; req_addr = 12'h005; req_wdata = 16'hDEAD;
        repeat (3) @(negedge clk);
        req_valid = 0;
        wait_idle();
        @(negedge clk);
        check(cmd_acc == 1, "R7", "accepts while busy", cmd_acc, 1);
        check(wd_acc == 0, "R7", "write data while busy", wd_acc, 0);
        rd_lat = 1;
        t_read(12'h005, old, 0, 1, "R7");
    endtask

    task automatic t_stall_flag();
        rd_lat = 30;
        do_req(0, 12'h001, 16'h0);
        repeat (3) @(negedge clk);
        window_end = 1;
        @(negedge clk);
        window_end = 0;
        check(err_flag == 1, "R8", "flag set by early window end", err_flag, 1);
        check(err_shadow == 0, "R10", "shadow not yet", err_shadow, 0);
        repeat (4) @(posedge obs_clk);
        #1;
        check(err_shadow == 1, "R10", "shadow follows set", err_shadow, 1);
        wait_idle();
        @(negedge clk);
        check(err_flag == 1, "R9", "flag sticky", err_flag, 1);
        err_clear = 1; window_end = 1;
        @(negedge clk);
        err_clear = 0; window_end = 0;
        check(err_flag == 0, "R9", "flag cleared", err_flag, 0);
        repeat (4) @(posedge obs_clk);
        #1;
        check(err_shadow == 0, "R10", "shadow follows clear", err_shadow, 0);
        @(negedge clk);
        window_end = 1;
        @(negedge clk);
        window_end = 0;
        check(err_flag == 0, "R8", "window end while idle", err_flag, 0);
        rd_lat = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0101);
        rst = 1; obs_rst = 1;
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        window_end = 0; err_clear = 0;
        cmd_rdy = 1; wd_rdy = 1; rsp_valid = 0; rsp_data = 0;
        repeat (4) @(negedge clk);
        rst = 0; obs_rst = 0;
        @(negedge clk);
        t_reset();
        t_write(12'h002, 16'hA5A5, 0, 0, "R2");
        t_read(12'h002, 16'hA5A5, 0, 1, "R6");
        t_read(12'h002, 16'hA5A5, 1, 2, "R3");
        t_read(12'h004, 16'h0404, 33, 3, "R4");
        t_write(12'h007, 16'h1234, 0, 5, "R5");
        t_read(12'h007, 16'h1234, 0, 1, "R5");
        t_write(12'h008, 16'h4321, 6, 0, "R5");
        t_read(12'h008, 16'h4321, 0, 4, "R5");
        t_write(12'h009, 16'hBEEF, 1, 33, "R4");
        t_read(12'h009, 16'hBEEF, 0, 1, "R4");
        t_ignore_busy();
        t_stall_flag();
        summary();
    end

endmodule